// File: doc/BRIEF.md
# Sized Integer ALU with Condition Flags

This block is a registered integer arithmetic and logic unit for a processor datapath. Each operation works on a byte, a word or a long slice of two 32-bit operands, a source and a destination. The block keeps a five-bit flag register holding extend (X), negative (N), zero (Z), overflow (V) and carry (C). A start strobe launches one operation. On the next clock edge the block registers the result and the updated flags, and it raises a done pulse for one cycle. Start may be held high for back-to-back operations, one per cycle.

Only the bits of the selected size take part in an operation. Result bits above that slice are copied from the destination operand. Every operation class has its own rule for the flags. Arithmetic sets all five flags and copies carry into extend. The extended forms take X as a carry or borrow input and keep Z sticky, so that a chain of operations over several words reports zero for the whole multi-word value. Logic, move and test operations clear V and C. Clear forces a fixed flag pattern. Compare updates the flags without changing the value.

Top module: `sized_cc_alu`

## Requirements
- R1: While rst_n is low, result, ccr and done are all zero. The flag layout in ccr is X=bit 4, N=bit 3, Z=bit 2, V=bit 1, C=bit 0.
- R2: done is high exactly in the cycle after a cycle with start high. result and ccr change only on that edge and otherwise hold their values.
- R3: size 0 selects byte (bits 7:0), 1 selects word (bits 15:0), and 2 or 3 select long. Result bits above the selected slice equal the destination operand.
- R4: N is the top bit of the selected slice of the flag value. Z tests only the bits of that slice.
- R5: ADD (op 0), SUB (op 1, dst minus src) and NEG (op 4, zero minus dst) write the sized result. C is the carry or borrow out of the slice, V is signed overflow at the selected size, and X is set equal to C.
- R6: ADDQ (op 6) adds and SUBQ (op 7) subtracts an immediate of 1 to 8 to or from dst. The immediate comes from qimm, where the value 0 encodes 8. The flags follow R5.
- R7: ADDX (op 2), SUBX (op 3) and NEGX (op 5) use X as the carry or borrow input. Z is cleared when the sized result is nonzero and otherwise keeps its previous value. N, V and C follow R5, and X equals C.
- R8: AND (op 8), OR (op 9), EOR (op 10), NOT of dst (op 11), MOVE of src (op 12) and TST of dst (op 13) set N and Z from the value, clear V and C, and leave X unchanged. TST leaves the result equal to dst.
- R9: CLR (op 14) zeroes the selected slice and sets N=0, Z=1, V=0 and C=0. X is unchanged.
- R10: CMP (op 15) sets N, Z, V and C as for dst minus src. The result equals dst, and X is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch an operation this cycle |
| op | input | 4 | Operation code (see requirements) |
| size | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| src | input | 32 | Source operand |
| dst | input | 32 | Destination operand |
| qimm | input | 3 | Quick immediate, 0 encodes 8 |
| result | output | 32 | Registered result |
| ccr | output | 5 | Flag register {X,N,Z,V,C} |
| done | output | 1 | Result and flags updated this cycle |

## Verification
The hardest case to reach is the sticky zero flag in an extended chain. An extended operation whose own result is zero must keep Z exactly as the previous operation left it. To observe this, the bench first sets Z with an equal subtraction and then runs a zero-producing SUBX, which must keep Z set. It then clears Z with a nonzero add and runs a zero-producing ADDX, which must keep Z clear. Further sequences carry X between words of a multi-word add. A long random run, with back-to-back starts across all sizes and operations, lets X and Z reach the extended forms in many different states.

// File: rtl/sized_cc_alu_pkg.sv
package sized_cc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADDX = 4'd2,
    OP_SUBX = 4'd3,
    OP_NEG  = 4'd4,
    OP_NEGX = 4'd5,
    OP_ADDQ = 4'd6,
    OP_SUBQ = 4'd7,
    OP_AND  = 4'd8,
    OP_OR   = 4'd9,
    OP_EOR  = 4'd10,
    OP_NOT  = 4'd11,
    OP_MOVE = 4'd12,
    OP_TST  = 4'd13,
    OP_CLR  = 4'd14,
    OP_CMP  = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    FC_ARITH,
    FC_EXTEND,
    FC_LOGIC,
    FC_CLEAR,
    FC_COMPARE
  } flag_class_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  localparam int CCR_W = 5;

endpackage

// File: rtl/sized_cc_alu_sizer.sv
module sized_cc_alu_sizer #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W + 1)
) (
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] mask,
  output logic [IDX_W-1:0]  top_idx
);

  localparam int NUM_SZ = 3;

  logic [DATA_W-1:0] mask_tab [NUM_SZ];
  logic [IDX_W-1:0]  idx_tab  [NUM_SZ];

  // one slice per size: byte = DATA_W/4, word = DATA_W/2, long = DATA_W
  for (genvar g = 0; g < NUM_SZ; g++) begin : g_size
    localparam int SLICE_W = DATA_W >> (NUM_SZ - 1 - g);
    if (SLICE_W == DATA_W) begin : g_full
      assign mask_tab[g] = '1;
    end else begin : g_part
      assign mask_tab[g] = {{(DATA_W-SLICE_W){1'b0}}, {SLICE_W{1'b1}}};
    end
    assign idx_tab[g] = IDX_W'(SLICE_W - 1);
  end

  always_comb begin
    case (size)
      2'd0:    begin mask = mask_tab[0]; top_idx = idx_tab[0]; end
      2'd1:    begin mask = mask_tab[1]; top_idx = idx_tab[1]; end
      default: begin mask = mask_tab[2]; top_idx = idx_tab[2]; end
    endcase
  end

endmodule

// File: rtl/sized_cc_alu_arith.sv
module sized_cc_alu_arith #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              inv_b,
  input  logic              cin,
  input  logic [DATA_W-1:0] mask,
  input  logic [IDX_W-1:0]  top_idx,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              ovf
);

  logic [DATA_W-1:0] a_m;
  logic [DATA_W-1:0] b_m;
  logic [DATA_W:0]   wide;
  logic              sa, sb, ss;

  always_comb begin
    a_m  = opa & mask;
    b_m  = (inv_b ? ~opb : opb) & mask;
    wide = {1'b0, a_m} + {1'b0, b_m} + {{DATA_W{1'b0}}, cin};
    sum  = wide[DATA_W-1:0] & mask;
    // masked operands leave the carry of the slice at one bit above its top
    cout = wide[top_idx + IDX_W'(1)];
    sa   = a_m[top_idx];
    sb   = b_m[top_idx];
    ss   = sum[top_idx];
    ovf  = (sa == sb) && (ss != sa);
  end

endmodule

// File: rtl/sized_cc_alu_logic.sv
module sized_cc_alu_logic #(
  parameter int DATA_W = 32
) (
  input  sized_cc_alu_pkg::alu_op_e op,
  input  logic [DATA_W-1:0]         src,
  input  logic [DATA_W-1:0]         dst,
  output logic [DATA_W-1:0]         lres
);
  import sized_cc_alu_pkg::*;

  always_comb begin
    case (op)
      OP_AND:  lres = dst & src;
      OP_OR:   lres = dst | src;
      OP_EOR:  lres = dst ^ src;
      OP_NOT:  lres = ~dst;
      OP_MOVE: lres = src;
      OP_CLR:  lres = '0;
      default: lres = dst;
    endcase
  end

endmodule

// File: rtl/sized_cc_alu_flags.sv
module sized_cc_alu_flags #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W + 1)
) (
  input  sized_cc_alu_pkg::flag_class_e fclass,
  input  logic [DATA_W-1:0]             fval,
  input  logic [IDX_W-1:0]              top_idx,
  input  logic                          carry,
  input  logic                          ovf,
  input  sized_cc_alu_pkg::ccr_t        ccr_q,
  output sized_cc_alu_pkg::ccr_t        ccr_d
);
  import sized_cc_alu_pkg::*;

  logic neg, zero;

  always_comb begin
    neg  = fval[top_idx];
    zero = (fval == '0);
    ccr_d = ccr_q;
    case (fclass)
      FC_ARITH: begin
        ccr_d = '{x: carry, n: neg, z: zero, v: ovf, c: carry};
      end
      FC_EXTEND: begin
        ccr_d = '{x: carry, n: neg, z: ccr_q.z & zero, v: ovf, c: carry};
      end
      FC_LOGIC: begin
        ccr_d = '{x: ccr_q.x, n: neg, z: zero, v: 1'b0, c: 1'b0};
      end
      FC_CLEAR: begin
        ccr_d = '{x: ccr_q.x, n: 1'b0, z: 1'b1, v: 1'b0, c: 1'b0};
      end
      FC_COMPARE: begin
        ccr_d = '{x: ccr_q.x, n: neg, z: zero, v: ovf, c: carry};
      end
      default: ccr_d = ccr_q;
    endcase
  end

endmodule

// File: rtl/sized_cc_alu.sv
module sized_cc_alu #(
  parameter int DATA_W = 32,
  parameter int QIMM_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        op,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  input  logic [QIMM_W-1:0] qimm,
  output logic [DATA_W-1:0] result,
  output logic [4:0]        ccr,
  output logic              done
);
  import sized_cc_alu_pkg::*;

  localparam int IDX_W  = $clog2(DATA_W + 1);
  localparam int QVAL_W = QIMM_W + 1;
  localparam logic [QVAL_W-1:0] QMAX = QVAL_W'(1) << QIMM_W;

  alu_op_e           op_e;
  logic [DATA_W-1:0] mask;
  logic [IDX_W-1:0]  top_idx;
  logic [DATA_W-1:0] opa, opb, qval;
  logic              inv_b, cin;
  logic [DATA_W-1:0] sum, lres;
  logic              cout, ovf, carry;
  flag_class_e       fclass;
  logic [DATA_W-1:0] low_val, fval, res_d;
  ccr_t              ccr_d, ccr_q;
  logic [DATA_W-1:0] res_q;
  logic              done_q;

  assign op_e = alu_op_e'(op);
  assign qval = {{(DATA_W-QVAL_W){1'b0}},
                 (qimm == '0) ? QMAX : {1'b0, qimm}};

  sized_cc_alu_sizer #(.DATA_W(DATA_W)) u_sizer (
    .size    (size),
    .mask    (mask),
    .top_idx (top_idx)
  );

  // operand steering for the shared adder
  always_comb begin
    opa    = dst;
    opb    = src;
    inv_b  = 1'b0;
    cin    = 1'b0;
    fclass = FC_LOGIC;
    case (op_e)
      OP_ADD:  begin fclass = FC_ARITH; end
      OP_SUB:  begin inv_b = 1'b1; cin = 1'b1; fclass = FC_ARITH; end
      OP_ADDX: begin cin = ccr_q.x; fclass = FC_EXTEND; end
      OP_SUBX: begin inv_b = 1'b1; cin = ~ccr_q.x; fclass = FC_EXTEND; end
      OP_NEG:  begin
        opa = '0; opb = dst; inv_b = 1'b1; cin = 1'b1; fclass = FC_ARITH;
      end
      OP_NEGX: begin
        opa = '0; opb = dst; inv_b = 1'b1; cin = ~ccr_q.x; fclass = FC_EXTEND;
      end
      OP_ADDQ: begin opb = qval; fclass = FC_ARITH; end
      OP_SUBQ: begin opb = qval; inv_b = 1'b1; cin = 1'b1; fclass = FC_ARITH; end
      OP_CLR:  begin fclass = FC_CLEAR; end
      OP_CMP:  begin inv_b = 1'b1; cin = 1'b1; fclass = FC_COMPARE; end
      default: begin fclass = FC_LOGIC; end
    endcase
  end

  sized_cc_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .opa     (opa),
    .opb     (opb),
    .inv_b   (inv_b),
    .cin     (cin),
    .mask    (mask),
    .top_idx (top_idx),
    .sum     (sum),
    .cout    (cout),
    .ovf     (ovf)
  );

  sized_cc_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op   (op_e),
    .src  (src),
    .dst  (dst),
    .lres (lres)
  );

  // subtract forms report borrow, the inverse of the adder carry
  assign carry = inv_b ? ~cout : cout;

  always_comb begin
    case (fclass)
      FC_ARITH, FC_EXTEND, FC_COMPARE: low_val = sum;
      default:                         low_val = lres & mask;
    endcase
    fval = low_val;
    if (op_e == OP_CMP || op_e == OP_TST) begin
      res_d = dst;
    end else begin
      res_d = (dst & ~mask) | (low_val & mask);
    end
  end

  sized_cc_alu_flags #(.DATA_W(DATA_W)) u_flags (
    .fclass  (fclass),
    .fval    (fval),
    .top_idx (top_idx),
    .carry   (carry),
    .ovf     (ovf),
    .ccr_q   (ccr_q),
    .ccr_d   (ccr_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= start;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ccr_q <= '0;
    end else if (start) begin
      res_q <= res_d;
      ccr_q <= ccr_d;
    end
  end

  assign result = res_q;
  assign ccr    = ccr_q;
  assign done   = done_q;

endmodule

// File: rtl/sized_cc_alu_chk.sv
module sized_cc_alu_chk #(
  parameter int DATA_W = 32,
  parameter int QIMM_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [3:0]        op,
  input logic [1:0]        size,
  input logic [DATA_W-1:0] src,
  input logic [DATA_W-1:0] dst,
  input logic [QIMM_W-1:0] qimm,
  input logic [DATA_W-1:0] result,
  input logic [4:0]        ccr,
  input logic              done
);

  localparam int BYTE_W = DATA_W / 4;
  localparam int WORD_W = DATA_W / 2;

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);  // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done && $stable(result) && $stable(ccr));  // R2
  AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    start && size == 2'd0 |=> result[DATA_W-1:BYTE_W] == $past(dst[DATA_W-1:BYTE_W]));  // R3
  AST_WORD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    start && size == 2'd1 |=> result[DATA_W-1:WORD_W] == $past(dst[DATA_W-1:WORD_W]));  // R3
  AST_ARITH_X_IS_C: assert property (@(posedge clk) disable iff (!rst_n)
    start && op < 4'd8 |=> ccr[4] == ccr[0]);  // R5
  AST_EXT_Z_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start && (op == 4'd2 || op == 4'd3 || op == 4'd5) && !ccr[2] |=> !ccr[2]);  // R7
  AST_LOGIC_VC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start && op >= 4'd8 && op <= 4'd13 |=> ccr[1:0] == 2'b00 && ccr[4] == $past(ccr[4]));  // R8
  AST_CLR_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    start && op == 4'd14 |=> ccr[3:0] == 4'b0100 && ccr[4] == $past(ccr[4]));  // R9
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    start && op == 4'd15 |=> result == $past(dst) && ccr[4] == $past(ccr[4]));  // R10

  always_comb begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (result == '0 && ccr == '0 && !done);  // R1
    end
  end

endmodule

bind sized_cc_alu sized_cc_alu_chk #(.DATA_W(DATA_W), .QIMM_W(QIMM_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .op     (op),
  .size   (size),
  .src    (src),
  .dst    (dst),
  .qimm   (qimm),
  .result (result),
  .ccr    (ccr),
  .done   (done)
);

// File: tb/sized_cc_alu_test.sv
module sized_cc_alu_test;

  typedef struct {
    logic [31:0] res;
    logic [4:0]  cc;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  size = '0;
  logic [31:0] src = '0;
  logic [31:0] dst = '0;
  logic [2:0]  qimm = '0;
  logic [31:0] result;
  logic [4:0]  ccr;
  logic        done;

  int     n_checks = 0;
  int     n_fail = 0;
  exp_t   sb_q[$];
  logic [4:0]  model_cc = '0;
  logic [31:0] last_res = '0;
  logic [4:0]  last_cc = '0;
  logic   mon_on = 1'b0;
  longint cycles = 0;

  always #2.5 clk = ~clk;

  sized_cc_alu uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .size(size),
    .src(src), .dst(dst), .qimm(qimm),
    .result(result), .ccr(ccr), .done(done)
  );

  // reference: signed/unsigned integer arithmetic at the chosen width
  function automatic exp_t model(input logic [3:0] o, input logic [1:0] sz,
                                 input logic [31:0] s, input logic [31:0] d,
                                 input logic [2:0] q, input logic [4:0] cc);
    exp_t   e;
    int     w;
    longint mx, smax, smin, ua, ub, sa, sb, r, sr, lo, qv;
    logic   xi, nf, zf, vf, cf, xf, addlike, arith;
    logic [31:0] m32;
    w    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    mx   = (longint'(1) << w) - 1;
    smax = (longint'(1) << (w - 1)) - 1;
    smin = -(longint'(1) << (w - 1));
    ua   = longint'(d) & mx;
    ub   = longint'(s) & mx;
    sa   = (ua > smax) ? ua - (mx + 1) : ua;
    sb   = (ub > smax) ? ub - (mx + 1) : ub;
    qv   = (q == 3'd0) ? 8 : longint'(q);
    xi   = cc[4];
    r = 0; sr = 0; addlike = 1'b1; arith = 1'b1; lo = 0;
    case (o)
      4'd0:  begin r = ua + ub;      sr = sa + sb; end
      4'd2:  begin r = ua + ub + xi; sr = sa + sb + xi; end
      4'd6:  begin r = ua + qv;      sr = sa + qv; end
      4'd1, 4'd15: begin r = ua - ub; sr = sa - sb; addlike = 1'b0; end
      4'd3:  begin r = ua - ub - xi; sr = sa - sb - xi; addlike = 1'b0; end
      4'd7:  begin r = ua - qv;      sr = sa - qv; addlike = 1'b0; end
      4'd4:  begin r = -ua;          sr = -sa; addlike = 1'b0; end
      4'd5:  begin r = -ua - xi;     sr = -sa - xi; addlike = 1'b0; end
      4'd8:  begin lo = ua & ub;  arith = 1'b0; end
      4'd9:  begin lo = ua | ub;  arith = 1'b0; end
      4'd10: begin lo = ua ^ ub;  arith = 1'b0; end
      4'd11: begin lo = mx - ua;  arith = 1'b0; end
      4'd12: begin lo = ub;       arith = 1'b0; end
      4'd13: begin lo = ua;       arith = 1'b0; end
      default: begin lo = 0;      arith = 1'b0; end
    endcase
    if (arith) lo = r & mx;
    nf = ((lo >> (w - 1)) & 1) != 0;
    zf = (lo == 0);
    cf = addlike ? (r > mx) : (r < 0);
    vf = (sr > smax) || (sr < smin);
    xf = cf;
    if (o == 4'd2 || o == 4'd3 || o == 4'd5) zf = cc[2] && zf;
    if (!arith) begin vf = 1'b0; cf = 1'b0; xf = cc[4]; end
    if (o == 4'd14) begin nf = 1'b0; zf = 1'b1; end
    if (o == 4'd15) xf = cc[4];
    m32 = 32'(mx);
    if (o == 4'd15 || o == 4'd13) e.res = d;
    else e.res = (d & ~m32) | (32'(lo) & m32);
    e.cc = {xf, nf, zf, vf, cf};
    return e;
  endfunction

  task automatic issue(input logic [3:0] o, input logic [1:0] sz,
                       input logic [31:0] s, input logic [31:0] d,
                       input logic [2:0] q, input string tag);
    exp_t e;
    @(negedge clk);
    op = o; size = sz; src = s; dst = d; qimm = q; start = 1'b1;
    e = model(o, sz, s, d, q, model_cc);
    e.tag = tag;
    model_cc = e.cc;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0;
      op = 4'(i); src = 32'hDEAD_0000 + 32'(i); dst = ~src;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (done) begin
        n_checks++;
        if (sb_q.size() == 0) begin
          n_fail++;
          $display("FAIL R2: done without a pending operation, actual done=1 expected 0");
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          if (result !== e.res || ccr !== e.cc) begin
            n_fail++;
            $display("FAIL %s: actual result=%h ccr=%b expected result=%h ccr=%b",
                     e.tag, result, ccr, e.res, e.cc);
          end
          last_res = e.res;
          last_cc = e.cc;
        end
      end else begin
        // R2: outputs hold while no operation completes
        n_checks++;
        if (result !== last_res || ccr !== last_cc) begin
          n_fail++;
          $display("FAIL R2: idle hold, actual result=%h ccr=%b expected result=%h ccr=%b",
                   result, ccr, last_res, last_cc);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_checks++;
    if (result !== '0 || ccr !== '0 || done !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: actual result=%h ccr=%b done=%b expected 0/00000/0",
               result, ccr, done);
    end
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle(2);

    // R5 / R3 / R4: byte add with overflow, upper bits from dst
    issue(4'd0, 2'd0, 32'h1122_3301, 32'hAABB_CC7F, 3'd0, "R5 byte add ovf");
    issue(4'd0, 2'd1, 32'h0000_0001, 32'h1234_FFFF, 3'd0, "R4 word add carry zero");
    issue(4'd1, 2'd2, 32'h0000_0002, 32'h0000_0001, 3'd0, "R5 long sub borrow");
    issue(4'd4, 2'd0, 32'h0, 32'hFFFF_FF80, 3'd0, "R5 neg byte min");
    issue(4'd4, 2'd1, 32'h0, 32'h5555_0000, 3'd0, "R5 neg zero");
    idle(2);
    // R6: quick forms, code 0 means 8
    issue(4'd6, 2'd0, 32'h0, 32'h0000_00F9, 3'd0, "R6 addq 8");
    issue(4'd7, 2'd1, 32'h0, 32'hABCD_0000, 3'd1, "R6 subq 1");
    issue(4'd6, 2'd2, 32'h0, 32'h7FFF_FFFC, 3'd5, "R6 addq ovf");
    // R7: multi-word add, sticky Z kept set, sticky Z kept clear
    issue(4'd0, 2'd2, 32'h8000_0000, 32'h8000_0000, 3'd0, "R7 low word");
    issue(4'd2, 2'd2, 32'h0000_0001, 32'h0000_0002, 3'd0, "R7 addx carry in");
    issue(4'd1, 2'd2, 32'h0000_0005, 32'h0000_0005, 3'd0, "R7 set Z");
    issue(4'd3, 2'd2, 32'h0000_0000, 32'h0000_0000, 3'd0, "R7 subx keeps Z");
    issue(4'd0, 2'd0, 32'h0000_0001, 32'h0000_0001, 3'd0, "R7 clear Z");
    issue(4'd2, 2'd0, 32'h0000_0000, 32'h0000_0000, 3'd0, "R7 addx keeps Z clear");
    issue(4'd1, 2'd0, 32'h0000_0001, 32'h0000_0000, 3'd0, "R7 set X");
    issue(4'd5, 2'd1, 32'h0, 32'h0000_0000, 3'd0, "R7 negx with X");
    issue(4'd3, 2'd0, 32'h0000_0010, 32'h0000_0010, 3'd0, "R7 subx borrow in");
    idle(1);
    // R8: logic group keeps X
    issue(4'd8,  2'd0, 32'hFFFF_FF0F, 32'h1234_56F0, 3'd0, "R8 and zero");
    issue(4'd9,  2'd1, 32'h0000_8000, 32'hCAFE_0001, 3'd0, "R8 or neg");
    issue(4'd10, 2'd2, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 3'd0, "R8 eor");
    issue(4'd11, 2'd0, 32'h0, 32'h7777_77FF, 3'd0, "R8 not");
    issue(4'd12, 2'd1, 32'h9999_8001, 32'h1111_2222, 3'd0, "R8 move");
    issue(4'd13, 2'd0, 32'hFFFF_FFFF, 32'h0000_0080, 3'd0, "R8 tst");
    // R9 / R10
    issue(4'd14, 2'd1, 32'h0, 32'hABCD_1234, 3'd0, "R9 clr word");
    issue(4'd15, 2'd2, 32'h0000_0003, 32'h0000_0001, 3'd0, "R10 cmp lower");
    issue(4'd15, 2'd0, 32'h0000_0080, 32'hFFFF_FF7F, 3'd0, "R10 cmp ovf");
    issue(4'd15, 2'd3, 32'h1234_5678, 32'h1234_5678, 3'd0, "R10 cmp equal size3");
    idle(3);

    // random back-to-back traffic over all ops and sizes
    for (int i = 0; i < 400; i++) begin
      issue(4'($urandom), 2'($urandom), $urandom, $urandom, 3'($urandom), "R3 R4 random");
      if (($urandom % 5) == 0) idle(1);
    end
    idle(4);
    for (int k = 0; k < 50 && sb_q.size() != 0; k++) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL R2: actual %0d results missing expected 0", sb_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL R2: watchdog expired, actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule